// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter with eight multiplexed inputs. A start strobe captures a 3-bit input number and a speed select. The block then drives the input-select lines and an 8-bit trial code to an external DAC and comparator. It reads back one comparator bit per decision and leaves the resolved code on a result output, with a done flag.

Timing is counted in instruction cycles of four system clocks each. At full speed a conversion takes 26 instruction cycles: a sampling window of 2 cycles, then eight decision steps of 3 cycles each. At half speed it takes 51 instruction cycles: 3 sampling cycles, then eight steps of 6 cycles each.

The controller has three states:
- `ST_IDLE` moves to `ST_SAMPLE` when a start arrives.
- `ST_SAMPLE` moves to `ST_DECIDE` when its window expires.
- `ST_DECIDE` stays in place from one bit to the next, and returns to `ST_IDLE` after the LSB decision.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o`, `trial_o` and `chan_o` are all zero.
- R2: A start strobe seen in idle makes `busy_o` high and `done_o` low from the next clock edge.
- R3: Input number and speed are captured on the accepted start; `chan_o` shows the captured number, and changes to `chan_sel_i` or `slow_i` while busy alter neither `chan_o` nor the timing.
- R4: With `slow_i` = 0, `busy_o` stays high for exactly 104 clocks (26 instruction cycles): 8 clocks of sampling, then eight steps of 12 clocks.
- R5: With `slow_i` = 1, `busy_o` stays high for exactly 204 clocks (51 instruction cycles): 12 clocks of sampling, then eight steps of 24 clocks.
- R6: `trial_o` is 0 during sampling and 0x80 in the first step. Each later step keeps the bits already decided and sets the next lower bit, MSB to LSB. `trial_o` does not change inside a step.
- R7: At the last clock of each step the trial bit is kept if `cmp_i` is 1 (input at or above the trial code) and cleared otherwise. With an ideal comparator, the result equals the input's code.
- R8: `done_o` rises on the same edge that `busy_o` falls and `result_o` is written. Both then hold until the next accepted start, which clears `done_o`.
- R9: A start strobe while busy is ignored: the conversion in progress keeps its input, speed, timing and result.
- R10: `trial_o` is zero whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled each clock |
| chan_sel_i | input | 3 | Input number to convert |
| slow_i | input | 1 | 0 = full speed (26 cycles), 1 = half speed (51 cycles) |
| cmp_i | input | 1 | Comparator: 1 when analog input >= trial code |
| chan_o | output | 3 | Captured input number driving the analog multiplexer |
| trial_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last resolved code |
| done_o | output | 1 | Result valid since the last accepted start |

## Verification
The assertions assume that `cmp_i` is a function of the current `chan_o` and `trial_o`, and that reset is applied before the first checked edge. The bench keeps to this by modelling the comparator as an ideal combinational compare of a per-input code against `trial_o`. It drives every input on the falling clock edge so that `start_i`, `chan_sel_i` and `slow_i` are stable at each rising edge. The input codes include 0, 1, 127, 128, 254 and 255. These exercise both the all-kept and the all-cleared decision paths, as well as the MSB boundary. Mid-conversion changes to the input number and the speed, and stray starts while busy, show that the captured values hold.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DECIDE = 2'd2
    } sar_state_e;

    function automatic int conv_clocks(input int samp, input int step,
                                       input int bits, input int cpc);
        return (samp + bits * step) * cpc;
    endfunction

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expire_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         first_i,
    input  logic         decide_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] resolved_o,
    output logic         last_o
);

    logic [W-1:0] code_q;
    logic [W-1:0] ptr_q;

    assign last_o  = ptr_q[0];
    assign trial_o = code_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic ptr_up;
        if (i == W - 1) begin : g_top
            assign ptr_up = 1'b0;
        end else begin : g_low
            assign ptr_up = ptr_q[i+1];
        end

        assign resolved_o[i] = ptr_q[i] ? (code_q[i] & cmp_i) : code_q[i];

        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                code_q[i] <= 1'b0;
                ptr_q[i]  <= 1'b0;
            end else if (first_i) begin
                code_q[i] <= (i == W - 1);
                ptr_q[i]  <= (i == W - 1);
            end else if (decide_i) begin
                if (last_o) begin
                    code_q[i] <= 1'b0;
                    ptr_q[i]  <= 1'b0;
                end else begin
                    code_q[i] <= resolved_o[i] | ptr_up;
                    ptr_q[i]  <= ptr_up;
                end
            end
        end
    end

    // R6: the first step presents only the MSB
    p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        first_i |=> trial_o == (W'(1) << (W - 1)));

    // R6: the trial code holds between step boundaries
    p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i || first_i || decide_i) |=> $stable(trial_o));

    // R10: the final decision returns the trial code to zero
    p_final_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && last_o) |=> trial_o == '0);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W       = 8,
    parameter int CH_W        = 3,
    parameter int CLK_PER_CYC = 4,
    parameter int SAMP_FAST   = 2,
    parameter int STEP_FAST   = 3,
    parameter int SAMP_SLOW   = 3,
    parameter int STEP_SLOW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_sel_i,
    input  logic             slow_i,
    input  logic             cmp_i,
    output logic [CH_W-1:0]  chan_o,
    output logic [RES_W-1:0] trial_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    import sar_pkg::*;

    localparam int SF_CLK  = SAMP_FAST * CLK_PER_CYC;
    localparam int TF_CLK  = STEP_FAST * CLK_PER_CYC;
    localparam int SS_CLK  = SAMP_SLOW * CLK_PER_CYC;
    localparam int TS_CLK  = STEP_SLOW * CLK_PER_CYC;
    localparam int MAX_A   = (SF_CLK > TF_CLK) ? SF_CLK : TF_CLK;
    localparam int MAX_B   = (SS_CLK > TS_CLK) ? SS_CLK : TS_CLK;
    localparam int TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int FAST_TOTAL = conv_clocks(SAMP_FAST, STEP_FAST, RES_W, CLK_PER_CYC);
    localparam int SLOW_TOTAL = conv_clocks(SAMP_SLOW, STEP_SLOW, RES_W, CLK_PER_CYC);

    localparam logic [TMR_W-1:0] SF_LD = TMR_W'(SF_CLK - 1);
    localparam logic [TMR_W-1:0] TF_LD = TMR_W'(TF_CLK - 1);
    localparam logic [TMR_W-1:0] SS_LD = TMR_W'(SS_CLK - 1);
    localparam logic [TMR_W-1:0] TS_LD = TMR_W'(TS_CLK - 1);

    sar_state_e state_q, state_d;

    logic              slow_q;
    logic [CH_W-1:0]   chan_q;
    logic [RES_W-1:0]  result_q;
    logic              done_q;

    logic              tmr_exp;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              last_bit;
    logic [RES_W-1:0]  resolved;

    logic accept, enter_dec, decide, finish;

    // control strobes
    always_comb begin
        accept    = (state_q == ST_IDLE)   && start_i;
        enter_dec = (state_q == ST_SAMPLE) && tmr_exp;
        decide    = (state_q == ST_DECIDE) && tmr_exp;
        finish    = decide && last_bit;
        tmr_load  = accept || enter_dec || (decide && !last_bit);
        if (accept) begin
            tmr_val = slow_i ? SS_LD : SF_LD;
        end else begin
            tmr_val = slow_q ? TS_LD : TF_LD;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)             state_d = ST_SAMPLE;
            ST_SAMPLE: if (tmr_exp)             state_d = ST_DECIDE;
            ST_DECIDE: if (tmr_exp && last_bit) state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= '0;
            slow_q   <= 1'b0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (accept) begin
                chan_q <= chan_sel_i;
                slow_q <= slow_i;
                done_q <= 1'b0;
            end
            if (finish) begin
                result_q <= resolved;
                done_q   <= 1'b1;
            end
        end
    end

    sar_step_timer #(.W(TMR_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_exp)
    );

    sar_bit_reg #(.W(RES_W)) i_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .first_i    (enter_dec),
        .decide_i   (decide),
        .cmp_i      (cmp_i),
        .trial_o    (trial_o),
        .resolved_o (resolved),
        .last_o     (last_bit)
    );

    assign chan_o   = chan_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign result_o = result_q;
    assign done_o   = done_q;

    // conversion length checker
    int unsigned len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            len_q <= 0;
        end else if (busy_o) begin
            len_q <= len_q + 1;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    p_hold_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(chan_o));

    p_conv_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (len_q == (slow_q ? SLOW_TOTAL : FAST_TOTAL)));

    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(result_o));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish) |=> (busy_o && $stable(slow_q)));

    p_idle_trial_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (trial_o == '0));

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_sel_i = '0;
    logic       slow_i = 1'b0;
    logic       cmp_i;
    logic [2:0] chan_o;
    logic [7:0] trial_o;
    logic       busy_o;
    logic [7:0] result_o;
    logic       done_o;

    int vin [8] = '{0, 255, 128, 127, 1, 200, 77, 254};
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign cmp_i = (vin[chan_o] >= int'(trial_o));

    sar_conv_seq i_sar_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .chan_sel_i (chan_sel_i),
        .slow_i     (slow_i),
        .cmp_i      (cmp_i),
        .chan_o     (chan_o),
        .trial_o    (trial_o),
        .busy_o     (busy_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    int m_busy = 0, m_done = 0, m_result = 0, m_trial = 0, m_chan = 0;
    int m_slow = 0, m_tick = 0, m_bit = 0;

    always @(posedge clk) begin
        int samp, step;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_result = 0; m_trial = 0; m_chan = 0;
            m_slow = 0; m_tick = 0; m_bit = 0;
        end else if (m_busy == 0) begin
            if (start_i) begin
                m_busy = 1; m_done = 0; m_chan = int'(chan_sel_i);
                m_slow = int'(slow_i); m_tick = 0; m_trial = 0;
            end
        end else begin
            samp = (m_slow != 0) ? 12 : 8;
            step = (m_slow != 0) ? 24 : 12;
            m_tick++;
            if (m_tick == samp) begin
                m_trial = 128;
                m_bit = 7;
            end else if (m_tick > samp && ((m_tick - samp) % step) == 0) begin
                if (!(vin[m_chan] >= m_trial))
                    m_trial = m_trial & ~(1 << m_bit);
                if (m_bit == 0) begin
                    m_result = m_trial;
                    m_done = 1;
                    m_busy = 0;
                    m_trial = 0;
                end else begin
                    m_bit--;
                    m_trial = m_trial | (1 << m_bit);
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 busy",   int'(busy_o),   m_busy);
            chk("R8 done",   int'(done_o),   m_done);
            chk("R7 result", int'(result_o), m_result);
            chk("R6 trial",  int'(trial_o),  m_trial);
            chk("R3 chan",   int'(chan_o),   m_chan);
        end
    end

    task automatic run_conv(input int ch, input bit slow, input bit disturb);
        int n;
        int exp_len;
        int res_keep;
        exp_len = slow ? 204 : 104;
        @(negedge clk);
        start_i = 1'b1; chan_sel_i = 3'(ch); slow_i = slow;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", int'(busy_o), 1);
        chk("R2 done cleared", int'(done_o), 0);
        n = 1;
        while (n < 400) begin
            @(negedge clk);
            if (!busy_o) break;
            n++;
            if (disturb && n == 20) begin
                start_i = 1'b1; chan_sel_i = 3'(ch ^ 5); slow_i = ~slow;
            end
            if (disturb && n == 21) start_i = 1'b0;
        end
        start_i = 1'b0;
        if (slow) chk("R5 half-speed length", n, exp_len);
        else      chk("R4 full-speed length", n, exp_len);
        chk("R7 result code", int'(result_o), vin[ch]);
        chk("R8 done at end", int'(done_o), 1);
        chk("R3 captured chan", int'(chan_o), ch);
        if (disturb) chk("R9 start while busy ignored", n, exp_len);
        res_keep = int'(result_o);
        repeat (6) @(negedge clk);
        chk("R8 done held", int'(done_o), 1);
        chk("R8 result held", int'(result_o), res_keep);
        chk("R10 trial idle", int'(trial_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy reset",   int'(busy_o),   0);
        chk("R1 done reset",   int'(done_o),   0);
        chk("R1 result reset", int'(result_o), 0);
        chk("R1 trial reset",  int'(trial_o),  0);
        chk("R1 chan reset",   int'(chan_o),   0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 8; c++) run_conv(c, 1'b0, 1'b0);
        for (int c = 0; c < 8; c++) run_conv(c, 1'b1, 1'b0);
        run_conv(3, 1'b0, 1'b1);
        run_conv(2, 1'b1, 1'b1);
        vin[6] = 170;
        run_conv(6, 1'b0, 1'b0);
        vin[6] = 85;
        run_conv(6, 1'b1, 1'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule